// File: doc/BRIEF.md
# SMBus Byte-Register Target with Three-Level Address Strapping

This block is a two-wire bus target that holds four 8-bit registers. It takes SCL and SDA after they have been synchronized and deglitched. It drives one output, an SDA pull-down enable. The contents of all four registers are also brought out, so neighbouring logic can use them. The block's 7-bit address is set by three strap inputs. Each strap reports one of three levels: tied low, tied high, or left open. The 27 possible combinations select an address from 0x40 up to 0x5A.

A master uses three transactions with the block:
- **Write Byte** sets the register pointer and supplies a data byte. The data is committed only when the transaction closes cleanly.
- **Read Byte** returns the register that the pointer currently selects.
- **Alert-response read** returns the block's own address.

The block also accepts a broadcast write address. A controller can use it to load every such target at once, whatever their straps.

Top module: `smb_regslave`

## Requirements
- R1: Each strap input is coded 2'b00 = tied low, 2'b01 = tied high, 2'b10 (or 2'b11) = open. For straps (adr2, adr1, adr0), the 7-bit address is 0x40 + n, where n follows the strap table. Examples: (low, open, low) gives 0x40, (low, low, low) gives 0x44, (open, open, open) gives 0x4A, (high, high, high) gives 0x55, (high, high, low) gives 0x58, (low, high, low) gives 0x59 and (open, high, low) gives 0x5A. The block acknowledges its own address.
- R2: The block does not pull SDA low in the ninth clock of an address byte that it does not recognize. It then acknowledges nothing and changes no register until the next Start.
- R3: In a Write Byte, the block acknowledges the address, command and data bytes. Bits 1:0 of the command byte select register k, and the upper six bits are ignored. Register k appears on reg_bank[8k+7:8k]. The data byte is stored there only when the Stop arrives, and reg_bank never changes except right after a Stop.
- R4: The block acknowledges the 8-bit write address 0xBA under any strap setting, and treats the rest of that transaction as a Write Byte. The read form, 0xBB, gets no acknowledge.
- R5: A Read Byte (own address with the R/W bit set) returns the register selected by the most recent command byte, most significant bit first.
- R6: A read at the 8-bit address 0x19 is acknowledged. The block then returns its own 7-bit address in bits 7:1, with bit 0 equal to 0.
- R7: A repeated Start, or a Stop in the middle of a byte, discards any pending write data, and so does any further clocking after the data byte's acknowledge. Both a Start and a Stop release SDA. In the over-clocking case, the extra byte is not acknowledged.
- R8: sda_pd changes only while SCL is low. It stays released during every bit that the master drives.
- R9: While reset is asserted, sda_pd is 0 and every register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized, filtered SCL |
| sda_i | input | 1 | Synchronized, filtered SDA (wired bus level) |
| adr2_lvl | input | 2 | Strap level for the most significant strap |
| adr1_lvl | input | 2 | Strap level for the middle strap |
| adr0_lvl | input | 2 | Strap level for the least significant strap |
| sda_pd | output | 1 | Pull SDA low when 1 |
| reg_bank | output | 32 | Four registers, register k at bits 8k+7:8k |

## Verification
The block detects SCL and SDA edges by comparing each input with its value from the previous clock. So an SCL fall shows up on sda_pd one clock later, and a Stop commits to reg_bank one clock after the rising SDA is sampled. The bench holds every bus phase for four clocks and samples in the middle of each SCL-high phase, which leaves at least three clocks of margin after each response is due. It reads register contents four clocks after the Stop, and before the Stop to confirm nothing was committed early. Acknowledge bits and read data are taken from the wired SDA level while SCL is high.

// File: rtl/smb_regslave.sv
module smb_regslave (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  adr2_lvl,
  input  logic [1:0]  adr1_lvl,
  input  logic [1:0]  adr0_lvl,
  output logic        sda_pd,
  output logic [31:0] reg_bank
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDAT, S_HOLD, S_TX, S_IGN} st_t;
  localparam logic [1:0] C_LO = 2'd0, C_HI = 2'd1, C_NC = 2'd2;
  localparam logic [7:0] BCAST_W = 8'hBA, ALERT_R = 8'h19;

  st_t        st, nxt;
  logic       scl_q, sda_q, ackph;
  logic [3:0] cnt;
  logic [7:0] sh, tx, wd;
  logic [1:0] sel;
  logic [1:0] c2, c1, c0;
  logic [2:0] sub;
  logic [4:0] idx;
  logic [6:0] own;

  function automatic logic [1:0] lvl(input logic [1:0] p);
    return (p == 2'b00) ? C_LO : (p == 2'b01) ? C_HI : C_NC;
  endfunction

  wire rise    = scl_i & ~scl_q;
  wire fall    = ~scl_i & scl_q;
  wire start_c = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c  = scl_i & scl_q & ~sda_q & sda_i;

  assign c2 = lvl(adr2_lvl);
  assign c1 = lvl(adr1_lvl);
  assign c0 = lvl(adr0_lvl);

  always_comb begin
    case ({c1, c0})
      {C_NC, C_LO}: sub = 3'd0;
      {C_HI, C_NC}: sub = 3'd1;
      {C_NC, C_NC}: sub = 3'd2;
      {C_NC, C_HI}: sub = 3'd3;
      {C_LO, C_LO}: sub = 3'd4;
      {C_HI, C_HI}: sub = 3'd5;
      {C_LO, C_NC}: sub = 3'd6;
      {C_LO, C_HI}: sub = 3'd7;
      default:      sub = 3'd0;
    endcase
    if (c1 == C_HI && c0 == C_LO)
      idx = (c2 == C_LO) ? 5'd25 : (c2 == C_HI) ? 5'd24 : 5'd26;
    else
      idx = {(c2 == C_LO) ? 2'd0 : (c2 == C_NC) ? 2'd1 : 2'd2, sub};
  end

  assign own = {2'b10, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE;
      scl_q <= 1'b1; sda_q <= 1'b1; ackph <= 1'b0;
      cnt <= '0; sh <= '0; tx <= '0; wd <= '0; sel <= '0;
      sda_pd <= 1'b0; reg_bank <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; ackph <= 1'b0; sda_pd <= 1'b0;
      end else if (stop_c) begin
        if (st == S_HOLD) reg_bank[{sel, 3'b000} +: 8] <= wd;
        st <= S_IDLE; cnt <= '0; ackph <= 1'b0; sda_pd <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8 && !ackph) begin
              ackph  <= 1'b1;
              sda_pd <= 1'b1;
              if (st == S_ADDR) begin
                if (sh == {own, 1'b0} || sh == BCAST_W) nxt <= S_CMD;
                else if (sh == {own, 1'b1}) begin
                  nxt <= S_TX; tx <= reg_bank[{sel, 3'b000} +: 8];
                end else if (sh == ALERT_R) begin
                  nxt <= S_TX; tx <= {own, 1'b0};
                end else begin
                  st <= S_IGN; ackph <= 1'b0; sda_pd <= 1'b0;
                end
              end else if (st == S_CMD) begin
                sel <= sh[1:0]; nxt <= S_WDAT;
              end else begin
                wd <= sh; nxt <= S_HOLD;
              end
            end else if (fall && ackph) begin
              ackph  <= 1'b0;
              cnt    <= '0;
              st     <= nxt;
              sda_pd <= (nxt == S_TX) ? ~tx[7] : 1'b0;
              tx     <= {tx[6:0], 1'b0};
            end
          end
          S_HOLD: if (fall) st <= S_IGN;
          S_TX: begin
            if (rise) cnt <= cnt + 4'd1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_pd <= 1'b0; st <= S_IGN;
              end else begin
                sda_pd <= ~tx[7]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_i,
  input logic        sda_pd,
  input logic [31:0] reg_bank
);

  assert_pd_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd) |-> !$past(scl_i));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (sda_pd == 1'b0 && reg_bank == 32'h0));

  assert_commit_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank) |-> ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2)));

  assert_start_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && $past(scl_i, 2) && !$past(sda_i) && $past(sda_i, 2)) |-> !sda_pd);

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2)) |-> !sda_pd);

endmodule

bind smb_regslave smb_regslave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_pd(sda_pd), .reg_bank(reg_bank)
);

// File: tb/test_smb_regslave.sv
module test_smb_regslave;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sdam = 1'b1;
  logic [1:0] a2 = 2'b10, a1 = 2'b10, a0 = 2'b10;
  logic pd;
  logic [31:0] bank;
  logic [31:0] exp_bank = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  wire sda = sdam & ~pd;

  always #4 clk = ~clk;

  smb_regslave i_smb_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .adr2_lvl(a2), .adr1_lvl(a1), .adr0_lvl(a0),
    .sda_pd(pd), .reg_bank(bank)
  );

  // {adr2, adr1, adr0, 7-bit address}; 00 low, 01 high, 10 open
  localparam logic [12:0] VEC [10] = '{
    {2'b00, 2'b10, 2'b00, 7'h40}, {2'b00, 2'b00, 2'b00, 7'h44},
    {2'b10, 2'b10, 2'b10, 7'h4A}, {2'b01, 2'b01, 2'b01, 7'h55},
    {2'b10, 2'b01, 2'b00, 7'h5A}, {2'b01, 2'b01, 2'b00, 7'h58},
    {2'b00, 2'b01, 2'b00, 7'h59}, {2'b00, 2'b01, 2'b10, 7'h41},
    {2'b01, 2'b00, 2'b01, 7'h57}, {2'b10, 2'b00, 2'b01, 7'h4F}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sdam = 1'b1; wq(); scl = 1'b1; wq(); sdam = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sdam = 1'b0; wq(); scl = 1'b1; wq(); sdam = 1'b1; wq();
  endtask

  task automatic send_bits(input int n, input logic [7:0] b, inout bit held);
    for (int i = 7; i > 7 - n; i--) begin
      sdam = b[i]; wq(); scl = 1'b1; wq();
      if (pd) held = 1'b1;
      scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, inout bit held);
    send_bits(8, b, held);
    sdam = 1'b1; wq(); scl = 1'b1; wq();
    acked = ~sda;
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sdam = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda; scl = 1'b0;
    end
    wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_write(input logic [7:0] a8, input logic [7:0] cmd, input logic [7:0] dat,
                          output logic [2:0] ak, inout bit held);
    bit k;
    bus_start();
    send_byte(a8, k, held);  ak[2] = k;
    send_byte(cmd, k, held); ak[1] = k;
    send_byte(dat, k, held); ak[0] = k;
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] a8, input logic [7:0] cmd, output logic [7:0] d,
                         output logic [2:0] ak);
    bit k, h;
    h = 1'b0;
    bus_start();
    send_byte(a8, k, h);  ak[2] = k;
    send_byte(cmd, k, h); ak[1] = k;
    bus_start();
    send_byte(a8 | 8'h01, k, h); ak[0] = k;
    recv_byte(d);
    bus_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic [2:0] ak;
    bit k, held;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 reset pull-down", {31'h0, pd}, 32'h0);
    chk("R9 reset registers", bank, 32'h0);
    rst_n = 1'b1;
    wq();

    foreach (VEC[v]) begin
      {a2, a1, a0} = VEC[v][12:7];
      held = 1'b0;
      bus_start(); send_byte(8'h19, k, held); recv_byte(d); bus_stop();
      chk("R6 alert ack", {31'h0, k}, 32'h1);
      chk("R1 R6 alert-returned address", {24'h0, d}, {24'h0, VEC[v][6:0], 1'b0});
      bus_start(); send_byte({VEC[v][6:0], 1'b0}, k, held); bus_stop();
      chk("R1 own address ack", {31'h0, k}, 32'h1);
    end

    {a2, a1, a0} = {2'b10, 2'b10, 2'b10};
    held = 1'b0;
    bus_start();
    send_byte(8'h94, k, held); ak[2] = k;
    send_byte(8'hFE, k, held); ak[1] = k;
    send_byte(8'h5C, k, held); ak[0] = k;
    chk("R3 write byte acks", {29'h0, ak}, 32'h7);
    chk("R3 no commit before stop", bank, exp_bank);
    bus_stop();
    exp_bank[23:16] = 8'h5C;
    chk("R3 commit at stop", bank, exp_bank);
    chk("R8 released during master bits", {31'h0, held}, 32'h0);

    do_write(8'h94, 8'h01, 8'hA3, ak, held);
    exp_bank[15:8] = 8'hA3;
    chk("R3 second write", bank, exp_bank);

    do_read(8'h94, 8'h02, d, ak);
    chk("R5 read acks", {29'h0, ak}, 32'h7);
    chk("R5 read reg2", {24'h0, d}, 32'h5C);
    do_read(8'h94, 8'h01, d, ak);
    chk("R5 read reg1", {24'h0, d}, 32'hA3);

    {a2, a1, a0} = {2'b01, 2'b01, 2'b01};
    do_write(8'hBA, 8'h03, 8'h71, ak, held);
    exp_bank[31:24] = 8'h71;
    chk("R4 broadcast acks", {29'h0, ak}, 32'h7);
    chk("R4 broadcast write", bank, exp_bank);
    {a2, a1, a0} = {2'b00, 2'b00, 2'b00};
    do_write(8'hBA, 8'h00, 8'h0F, ak, held);
    exp_bank[7:0] = 8'h0F;
    chk("R4 broadcast other straps", bank, exp_bank);
    bus_start(); send_byte(8'hBB, k, held); bus_stop();
    chk("R4 broadcast read nack", {31'h0, k}, 32'h0);

    do_write(8'h94, 8'h00, 8'h33, ak, held);
    chk("R2 foreign address nacks", {29'h0, ak}, 32'h0);
    chk("R2 no register change", bank, exp_bank);

    bus_start();
    send_byte(8'h88, k, held); send_byte(8'h00, k, held); send_byte(8'h99, k, held);
    bus_start(); bus_stop();
    chk("R7 repeated start discards", bank, exp_bank);

    bus_start();
    send_byte(8'h88, k, held); send_byte(8'h01, k, held);
    send_bits(4, 8'hF0, held);
    bus_stop();
    chk("R7 mid-byte stop discards", bank, exp_bank);

    bus_start();
    send_byte(8'h88, k, held); send_byte(8'h02, k, held); send_byte(8'h11, k, held);
    send_byte(8'h22, k, held);
    chk("R7 extra byte nack", {31'h0, k}, 32'h0);
    bus_stop();
    chk("R7 extra byte discards", bank, exp_bank);

    do_write(8'h88, 8'h02, 8'h11, ak, held);
    exp_bank[23:16] = 8'h11;
    chk("R7 recovery write", bank, exp_bank);
    do_read(8'h88, 8'h03, d, ak);
    chk("R5 read reg3", {24'h0, d}, 32'h71);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule